// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execution stage of a small processor datapath. Two operands and an operation code enter; the result leaves through a combinational path in the same cycle. Alongside it sits a four-bit condition register holding negative (N), zero (Z), overflow (V) and carry (C). That register is loaded on a rising clock edge only when the caller asks for flags to be set.

The operations are:
- add and subtract, each with a variant that folds in the stored carry;
- the bitwise AND, OR and XOR, plus three forms that invert the second operand first;
- three shifts: left, logical right and arithmetic right.

The carry-consuming variants read the flag register as it stands, so a chain of operations builds multi-word arithmetic.

Top module: `alu_cc_unit`

## Requirements
- R1: Operation code 0 (add) gives result = a + b modulo 2^32. When flags are set, C becomes the carry out of bit 31.
- R2: For add and add-with-carry, V is set when a and b share a sign bit and the result's sign bit differs from it.
- R3: Operation code 2 (subtract) gives result = a - b modulo 2^32. C is set when a is unsigned-less-than b. V is set when the operand signs differ and the result sign differs from a's sign.
- R4: Operation codes 1 (add-with-carry) and 3 (subtract-with-borrow) add, or subtract, the stored C as an extra 1. C is taken from the full 33-bit sum or difference.
- R5: Every flag-setting operation loads Z = (result == 0) and N = result bit 31. Flag bit positions are N=3, Z=2, V=1, C=0.
- R6: The logic operations clear V and C when flags are set:
  - code 4 is AND, 5 is OR and 6 is XOR;
  - codes 7, 8 and 9 invert b before AND, OR and XOR respectively.
- R7: The shifts use the low 5 bits of b as the shift amount, and clear V and C when flags are set:
  - code 10 shifts left, filling with zeros;
  - code 11 shifts right, filling with zeros;
  - code 12 shifts right, replicating bit 31.
- R8: The flag register changes only at a rising edge with set_flags high. Otherwise it holds its value.
- R9: A synchronous active-high reset clears all four flags.
- R10: Codes 13 to 15 give result 0. With set_flags they load Z=1 and clear N, V and C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand / shift amount |
| op_sel | input | 4 | Operation code |
| set_flags | input | 1 | Load the flag register at the next edge |
| result | output | 32 | Combinational result |
| flags | output | 4 | Stored flags {N,Z,V,C} |

## Verification
Some properties are checked by assertions on every cycle:
- flags hold when set_flags is low;
- Z and N agree with the previous result;
- logic and shift operations leave V and C clear;
- reset zeroes the register;
- an arithmetic right shift keeps the sign;
- an add that reports carry has wrapped.

Other properties only the bench's sweep can show: the exact result values, the precise overflow and borrow rules, and the correct use of the stored carry by the chained variants. The sweep covers every operation code against corner operands with the stored carry both clear and set.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_ADDC = 4'd1,  OP_SUB  = 4'd2,  OP_SUBB = 4'd3,
    OP_AND  = 4'd4,  OP_OR   = 4'd5,  OP_XOR  = 4'd6,  OP_ANDN = 4'd7,
    OP_ORN  = 4'd8,  OP_XNOR = 4'd9,  OP_SHL  = 4'd10, OP_SHR  = 4'd11,
    OP_SAR  = 4'd12
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  logic [W:0] ext;

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    else     ext = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  end

  assign sum  = ext[W-1:0];
  assign cout = ext[W];
  assign ovf  = sub ? ((a[W-1] ^ b[W-1]) & (a[W-1] ^ sum[W-1]))
                    : (~(a[W-1] ^ b[W-1]) & (a[W-1] ^ sum[W-1]));

  // R1: an add reporting carry must have wrapped to no more than a
  always_comb begin
    a_r1_carry_wrap: assert (sub || !cout || (sum <= a));
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [1:0]   fn,      // 0 and, 1 or, 2 xor
  input  logic         inv_b,
  output logic [W-1:0] res
);
  logic [W-1:0] b_eff;
  assign b_eff = inv_b ? ~b : b;

  always_comb begin
    unique case (fn)
      2'd0:    res = a & b_eff;
      2'd1:    res = a | b_eff;
      default: res = a ^ b_eff;
    endcase
  end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic [W-1:0]   a,
  input  logic [SHW-1:0] amt,
  input  logic [1:0]     mode,   // 0 left, 1 logical right, 2 arithmetic right
  output logic [W-1:0]   res
);
  always_comb begin
    unique case (mode)
      2'd0:    res = a << amt;
      2'd1:    res = a >> amt;
      default: res = W'($signed(a) >>> amt);
    endcase
  end

  // R7: arithmetic right shift keeps the sign bit
  always_comb begin
    a_r7_sar_sign: assert (mode != 2'd2 || res[W-1] == a[W-1]);
  end
endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit #(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   op_sel,
  input  logic         set_flags,
  output logic [W-1:0] result,
  output logic [3:0]   flags
);
  import alu_cc_pkg::*;

  alu_op_e   op;
  cc_flags_t flags_q, flags_d;
  logic [W-1:0] as_res, lg_res, sh_res;
  logic as_cout, as_ovf, use_cin, is_sub, is_arith, is_logic, is_shift;
  logic [1:0] lg_fn;

  assign op       = alu_op_e'(op_sel);
  assign is_arith = (op_sel <= 4'd3);
  assign is_logic = (op_sel >= 4'd4) && (op_sel <= 4'd9);
  assign is_shift = (op_sel >= 4'd10) && (op_sel <= 4'd12);
  assign is_sub   = (op == OP_SUB) || (op == OP_SUBB);
  assign use_cin  = ((op == OP_ADDC) || (op == OP_SUBB)) && flags_q.c;
  assign lg_fn    = (op_sel >= 4'd7) ? 2'(op_sel - 4'd7) : 2'(op_sel - 4'd4);

  alu_addsub #(.W(W)) u_addsub (
    .a(op_a), .b(op_b), .cin(use_cin), .sub(is_sub),
    .sum(as_res), .cout(as_cout), .ovf(as_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a(op_a), .b(op_b), .fn(lg_fn), .inv_b(op_sel >= 4'd7), .res(lg_res)
  );

  alu_shift #(.W(W)) u_shift (
    .a(op_a), .amt(op_b[SHW-1:0]), .mode(2'(op_sel - 4'd10)), .res(sh_res)
  );

  always_comb begin
    if (is_arith)      result = as_res;
    else if (is_logic) result = lg_res;
    else if (is_shift) result = sh_res;
    else               result = '0;
  end

  always_comb begin
    flags_d   = '0;
    flags_d.n = result[W-1];
    flags_d.z = (result == '0);
    if (is_arith) begin
      flags_d.v = as_ovf;
      flags_d.c = as_cout;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            flags_q <= '0;
    else if (set_flags) flags_q <= flags_d;
  end

  assign flags = flags_q;

  // R8: no load request, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !set_flags |=> $stable(flags_q));
  // R5: zero and sign flags follow the result that was loaded
  a_r5_zero_sign: assert property (@(posedge clk) disable iff (rst)
    set_flags |=> (flags_q.z == ($past(result) == '0)) && (flags_q.n == $past(result[W-1])));
  // R6: non-arithmetic operations leave V and C clear
  a_r6_vc_clear: assert property (@(posedge clk) disable iff (rst)
    (set_flags && !is_arith) |=> (!flags_q.v && !flags_q.c));
  // R9: reset zeroes the flags
  a_r9_reset: assert property (@(posedge clk) rst |=> (flags_q == '0));
endmodule

// File: tb/alu_cc_unit_tb.sv
module alu_cc_unit_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] op_a = 0, op_b = 0;
  logic [3:0]  op_sel = 0;
  logic        set_flags = 0;
  logic [31:0] result;
  logic [3:0]  flags;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  alu_cc_unit dut_i (.clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b),
    .op_sel(op_sel), .set_flags(set_flags), .result(result), .flags(flags));

  function automatic logic [35:0] model(input logic [3:0] op, input logic [31:0] a,
                                       input logic [31:0] b, input logic cin);
    logic [32:0] e; logic [31:0] r; logic v, c;
    v = 0; c = 0; r = 0;
    case (op)
      0, 1: begin e = 33'(a) + 33'(b) + 33'(op == 1 && cin); r = e[31:0]; c = e[32];
                  v = (a[31] == b[31]) && (r[31] != a[31]); end
      2, 3: begin e = 33'(a) - 33'(b) - 33'(op == 3 && cin); r = e[31:0]; c = e[32];
                  v = (a[31] != b[31]) && (r[31] != a[31]); end
      4: r = a & b;   5: r = a | b;   6: r = a ^ b;
      7: r = a & ~b;  8: r = a | ~b;  9: r = a ^ ~b;
      10: r = a << b[4:0];
      11: r = a >> b[4:0];
      12: for (int i = 0; i < 32; i++) r[i] = (i + b[4:0] > 31) ? a[31] : a[i + b[4:0]];
      default: r = 0;
    endcase
    return {r, r[31], (r == 0), v, c};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [3:0] op);
    case (op)
      0: return "R1"; 1, 3: return "R4"; 2: return "R3";
      4, 5, 6, 7, 8, 9: return "R6"; 10, 11, 12: return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic load_carry(input logic c);
    op_sel = 0; op_a = 32'hffff_ffff; op_b = {31'd0, c}; set_flags = 1;
    @(negedge clk);
  endtask

  logic [31:0] pats [8] = '{32'h0, 32'h1, 32'h7fff_ffff, 32'h8000_0000,
                           32'hffff_ffff, 32'h1234_5678, 32'hedcb_a987, 32'h0000_001f};

  initial begin
    logic [35:0] m;
    logic [3:0]  held;
    repeat (3) @(negedge clk);
    check("R9 reset", {28'd0, flags}, 32'd0);
    rst = 0;
    // R5 / R2 spot: 0x7fffffff + 1 overflows
    op_sel = 0; op_a = 32'h7fff_ffff; op_b = 1; set_flags = 1;
    @(negedge clk);
    check("R2 overflow", {28'd0, flags}, 32'b1010);
    // R8: flags hold with set_flags low
    held = flags; set_flags = 0; op_a = 0; op_b = 0;
    repeat (2) @(negedge clk);
    check("R8 hold", {28'd0, flags}, {28'd0, held});
    for (int op = 0; op < 16; op++)
      for (int ci = 0; ci < 2; ci++)
        for (int i = 0; i < 8; i++)
          for (int j = 0; j < 8; j++) begin
            load_carry(ci[0]);
            op_sel = op[3:0]; op_a = pats[i]; op_b = pats[j]; set_flags = 1;
            m = model(op[3:0], pats[i], pats[j], ci[0]);
            #1;
            check(req_of(op[3:0]), result, m[35:4]);
            @(negedge clk);
            check({req_of(op[3:0]), " R5 flags"}, {28'd0, flags}, {28'd0, m[3:0]});
          end
    // R9: reset mid-run clears flags
    load_carry(1'b1);
    set_flags = 0; rst = 1;
    @(negedge clk);
    check("R9 mid reset", {28'd0, flags}, 32'd0);
    rst = 0;
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule